// File: doc/BRIEF.md
# Wormhole Header Router

This block sits behind one receiving link and routes each packet that arrives on that link by its leading address byte. Tokens carry either a data byte or an end-of-packet marker of one of two kinds. Every link port and the local node have a programmable address. When routing is on, the block takes the first data token of a packet as the destination, discards it, and sends the rest of the packet to one of the other link outputs or to the local receive FIFO. The route is held until the end-of-packet marker has passed.

If no address matches, the packet still goes to the local FIFO and a one-cycle error interrupt is raised unless it is masked. The receiving link's own address never counts as a match. When routing is off, every token goes unchanged to the local FIFO. All outputs use valid/ready handshakes. The block forwards combinationally and holds its input while the selected output stalls, so no token is ever lost.

Top module: `wh_router`

## Requirements
- R1: A token is ADDR_W+1 bits wide. The top bit set marks a control token, whose bit 0 selects EOP1 (0) or EOP2 (1). Every forwarded token, control tokens included, appears at its output bit for bit unchanged.
- R2: With routing enabled, the first data token after reset, or after a forwarded end-of-packet token, is the header. It is accepted in the same cycle regardless of output readiness and appears on no output.
- R3: A header equal to the address of another link port sends the rest of the packet to that link's output.
- R4: A header equal to the local node address sends the rest of the packet to the local output.
- R5: The address of the receiving link (index RX_LINK) never matches. Its output never asserts valid.
- R6: A header that matches nothing sends the packet to the local output. irq_o then goes high for exactly the one cycle after the header is accepted, unless irq_mask_i is high.
- R7: The route chosen by a header is held for every token up to and including the end-of-packet token. The next data token is then a new header.
- R8: While the selected output is not ready, in_ready_o stays low. Tokens are delivered in order, with none dropped or duplicated.
- R9: With routing disabled, every token goes unchanged to the local output, with no header removed and no interrupt.
- R10: If several link addresses match, the lowest link index wins. A link match takes precedence over a local node match.
- R11: A control token that arrives while no packet is open goes to the local output and opens no route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| route_en_i | input | 1 | Routing enable |
| link_addr_i | input | NUM_LINKS*ADDR_W | Address of each link port, link i in slice i |
| node_addr_i | input | ADDR_W | Local node address |
| irq_mask_i | input | 1 | Masks the unmatched-address interrupt |
| in_valid_i | input | 1 | Input token valid |
| in_tok_i | input | ADDR_W+1 | Input token |
| in_ready_o | output | 1 | Input token accepted |
| lnk_valid_o | output | NUM_LINKS | Per-link output valid |
| lnk_tok_o | output | NUM_LINKS*(ADDR_W+1) | Per-link output token |
| lnk_ready_i | input | NUM_LINKS | Per-link output ready |
| loc_valid_o | output | 1 | Local FIFO output valid |
| loc_tok_o | output | ADDR_W+1 | Local FIFO output token |
| loc_ready_i | input | 1 | Local FIFO ready |
| irq_o | output | 1 | Unmatched-address interrupt pulse |

## Verification
The bench builds the block with three links, 8-bit addresses and RX_LINK set to 1, so the receiving link has a neighbour on each side. This exercises own-address exclusion together with link-order priority in both directions. Addresses change between phases, which produces multi-way matches and link-versus-local conflicts. Random output readiness produces stalls in the middle of packets.

// File: rtl/wh_router_pkg.sv
package wh_router_pkg;
  typedef enum logic {RS_HDR = 1'b0, RS_BODY = 1'b1} rstate_e;
endpackage

// File: rtl/wh_addr_match.sv
module wh_addr_match #(
  parameter int NUM_LINKS = 3,
  parameter int ADDR_W    = 8,
  parameter int RX_LINK   = 0
) (
  input  logic [ADDR_W-1:0]           hdr_i,
  input  logic [NUM_LINKS*ADDR_W-1:0] link_addr_i,
  input  logic [ADDR_W-1:0]           node_addr_i,
  output logic [NUM_LINKS:0]          dest_o,
  output logic                        miss_o
);
  logic [NUM_LINKS-1:0] hit;

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_cmp
    if (g == RX_LINK) begin : g_own
      assign hit[g] = 1'b0;  // receiving link never matches
    end else begin : g_other
      assign hit[g] = (link_addr_i[g*ADDR_W +: ADDR_W] == hdr_i);
    end
  end

  logic found;
  always_comb begin
    dest_o = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (hit[i] && !found) begin
        dest_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
    if (!found) dest_o[NUM_LINKS] = 1'b1;
    miss_o = !found && (node_addr_i != hdr_i);
  end
endmodule

// File: rtl/wh_steer.sv
module wh_steer #(
  parameter int NUM_LINKS = 3,
  parameter int TOK_W     = 9
) (
  input  logic                       valid_i,
  input  logic [TOK_W-1:0]           tok_i,
  input  logic [NUM_LINKS:0]         sel_i,
  input  logic [NUM_LINKS-1:0]       lnk_ready_i,
  input  logic                       loc_ready_i,
  output logic [NUM_LINKS-1:0]       lnk_valid_o,
  output logic [NUM_LINKS*TOK_W-1:0] lnk_tok_o,
  output logic                       loc_valid_o,
  output logic [TOK_W-1:0]           loc_tok_o,
  output logic                       sel_ready_o
);
  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_lane
    assign lnk_valid_o[g]               = valid_i & sel_i[g];
    assign lnk_tok_o[g*TOK_W +: TOK_W]  = tok_i;
  end
  assign loc_valid_o = valid_i & sel_i[NUM_LINKS];
  assign loc_tok_o   = tok_i;
  assign sel_ready_o = |(sel_i & {loc_ready_i, lnk_ready_i});
endmodule

// File: rtl/wh_router.sv
module wh_router
  import wh_router_pkg::*;
#(
  parameter int NUM_LINKS = 3,
  parameter int ADDR_W    = 8,
  parameter int RX_LINK   = 0,
  localparam int TOK_W    = ADDR_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        route_en_i,
  input  logic [NUM_LINKS*ADDR_W-1:0] link_addr_i,
  input  logic [ADDR_W-1:0]           node_addr_i,
  input  logic                        irq_mask_i,
  input  logic                        in_valid_i,
  input  logic [TOK_W-1:0]            in_tok_i,
  output logic                        in_ready_o,
  output logic [NUM_LINKS-1:0]        lnk_valid_o,
  output logic [NUM_LINKS*TOK_W-1:0]  lnk_tok_o,
  input  logic [NUM_LINKS-1:0]        lnk_ready_i,
  output logic                        loc_valid_o,
  output logic [TOK_W-1:0]            loc_tok_o,
  input  logic                        loc_ready_i,
  output logic                        irq_o
);
  localparam logic [NUM_LINKS:0] SEL_LOC = {1'b1, {NUM_LINKS{1'b0}}};

  rstate_e              state_q;
  logic [NUM_LINKS:0]   route_q;
  logic                 err_q;
  logic [NUM_LINKS:0]   dest;
  logic                 miss;
  logic [NUM_LINKS:0]   sel;
  logic                 sel_ready;
  logic                 is_ctl;
  logic                 hdr_phase;
  logic                 fwd_valid;

  assign is_ctl    = in_tok_i[ADDR_W];
  assign hdr_phase = route_en_i && (state_q == RS_HDR) && !is_ctl;
  assign sel       = (route_en_i && state_q == RS_BODY) ? route_q : SEL_LOC;
  assign fwd_valid = in_valid_i && !hdr_phase;
  assign in_ready_o = hdr_phase ? 1'b1 : sel_ready;

  wh_addr_match #(.NUM_LINKS(NUM_LINKS), .ADDR_W(ADDR_W), .RX_LINK(RX_LINK)) i_match (
    .hdr_i       (in_tok_i[ADDR_W-1:0]),
    .link_addr_i (link_addr_i),
    .node_addr_i (node_addr_i),
    .dest_o      (dest),
    .miss_o      (miss)
  );

  wh_steer #(.NUM_LINKS(NUM_LINKS), .TOK_W(TOK_W)) i_steer (
    .valid_i     (fwd_valid),
    .tok_i       (in_tok_i),
    .sel_i       (sel),
    .lnk_ready_i (lnk_ready_i),
    .loc_ready_i (loc_ready_i),
    .lnk_valid_o (lnk_valid_o),
    .lnk_tok_o   (lnk_tok_o),
    .loc_valid_o (loc_valid_o),
    .loc_tok_o   (loc_tok_o),
    .sel_ready_o (sel_ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_HDR;
      route_q <= SEL_LOC;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!route_en_i) begin
        state_q <= RS_HDR;
      end else if (in_valid_i && hdr_phase) begin
        state_q <= RS_BODY;
        route_q <= dest;
        err_q   <= miss;
      end else if (state_q == RS_BODY && in_valid_i && in_ready_o && is_ctl) begin
        state_q <= RS_HDR;  // EOP forwarded: release route
      end
    end
  end

  assign irq_o = err_q & ~irq_mask_i;

  // R2: header is swallowed
  a_r2_hdr_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && hdr_phase) |-> (!(|lnk_valid_o) && !loc_valid_o));
  // R5: own link output stays idle
  a_r5_own_link_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lnk_valid_o[RX_LINK]);
  // R6: interrupt only right after an accepted header
  a_r6_irq_after_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(in_valid_i && in_ready_o && hdr_phase));
  // R7: route held inside a packet
  a_r7_route_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_en_i && state_q == RS_BODY && !(in_valid_i && in_ready_o && is_ctl))
      |=> $stable(route_q));
  // R8: acceptance tracks the selected output handshake
  a_r8_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !hdr_phase) |->
      (in_ready_o == (|{lnk_valid_o & lnk_ready_i, loc_valid_o & loc_ready_i})));
  // R8: at most one output carries a token
  a_r8_single_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lnk_valid_o, loc_valid_o}));
endmodule

// File: tb/test_wh_router.sv
module test_wh_router;
  localparam int NL = 3;
  localparam int AW = 8;
  localparam int TW = AW + 1;
  localparam int RX = 1;
  localparam int LOC = NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              route_en = 1'b0;
  logic [NL*AW-1:0]  link_addr;
  logic [AW-1:0]     node_addr = 8'h40;
  logic              irq_mask = 1'b0;
  logic              in_valid = 1'b0;
  logic [TW-1:0]     in_tok = '0;
  logic              in_ready;
  logic [NL-1:0]     lnk_valid;
  logic [NL*TW-1:0]  lnk_tok;
  logic [NL-1:0]     lnk_rdy = '1;
  logic              loc_valid;
  logic [TW-1:0]     loc_tok;
  logic              loc_rdy = 1'b1;
  logic              irq;

  wh_router #(.NUM_LINKS(NL), .ADDR_W(AW), .RX_LINK(RX)) i_wh_router (
    .clk_i(clk), .rst_ni(rst_n), .route_en_i(route_en), .link_addr_i(link_addr),
    .node_addr_i(node_addr), .irq_mask_i(irq_mask), .in_valid_i(in_valid),
    .in_tok_i(in_tok), .in_ready_o(in_ready), .lnk_valid_o(lnk_valid),
    .lnk_tok_o(lnk_tok), .lnk_ready_i(lnk_rdy), .loc_valid_o(loc_valid),
    .loc_tok_o(loc_tok), .loc_ready_i(loc_rdy), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int exp_irq = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  logic [TW-1:0] exp_q [4][$];

  function automatic logic [TW-1:0] dt(input logic [AW-1:0] b);
    return {1'b0, b};
  endfunction
  localparam logic [TW-1:0] EOP1 = {1'b1, 8'h00};
  localparam logic [TW-1:0] EOP2 = {1'b1, 8'h01};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // random output backpressure
  always @(posedge clk) begin
    #1;
    if (stall_en) begin
      lnk_rdy <= NL'($urandom);
      loc_rdy <= ($urandom % 3) != 0;
    end else begin
      lnk_rdy <= '1;
      loc_rdy <= 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NL; i++) begin
        if (lnk_valid[i] && lnk_rdy[i]) begin
          if (exp_q[i].size() == 0)
            check(1'b0, "R8 unexpected link token", int'(lnk_tok[i*TW +: TW]), -1);
          else begin
            logic [TW-1:0] e;
            e = exp_q[i].pop_front();
            check(lnk_tok[i*TW +: TW] == e, "R1/R3/R7 link token", int'(lnk_tok[i*TW +: TW]), int'(e));
          end
        end
      end
      if (lnk_valid[RX]) check(1'b0, "R5 own link valid", 1, 0);
      if (loc_valid && loc_rdy) begin
        if (exp_q[LOC].size() == 0)
          check(1'b0, "R8 unexpected local token", int'(loc_tok), -1);
        else begin
          logic [TW-1:0] e;
          e = exp_q[LOC].pop_front();
          check(loc_tok == e, "R4/R9 local token", int'(loc_tok), int'(e));
        end
      end
      if (irq) irq_cnt++;
    end
  end

  task automatic send_tok(input logic [TW-1:0] t, input int d);
    bit ok;
    if (d >= 0) exp_q[d].push_back(t);
    in_valid = 1'b1;
    in_tok   = t;
    ok = 1'b0;
    while (!ok) begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  // header (dropped if routed), n bytes, eop
  task automatic send_pkt(input logic [AW-1:0] hdr, input int n, input logic [TW-1:0] eop,
                          input int d, input bit hdr_kept);
    send_tok(dt(hdr), hdr_kept ? d : -1);
    for (int k = 0; k < n; k++) send_tok(dt(AW'(hdr + k * 7 + 1)), d);
    send_tok(eop, d);
  endtask

  task automatic drain(input string req);
    repeat (20) @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++)
      check(exp_q[i].size() == 0, req, exp_q[i].size(), 0);
    check(irq_cnt == exp_irq, "R6 irq count", irq_cnt, exp_irq);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    finish_up();
  end

  initial begin
    link_addr = {8'h32, 8'h21, 8'h10};  // L2, L1 (own), L0
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(lnk_valid == '0 && !loc_valid && !irq, "reset outputs idle",
          int'({lnk_valid, loc_valid, irq}), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R9: routing disabled
    send_pkt(8'h10, 3, EOP1, LOC, 1'b1);
    drain("R9 pass-through");

    route_en = 1'b1;
    // R11: lone control token
    send_tok(EOP2, LOC);
    // R2 R3: to link 0, then link 2 (R7 back to back, EOP2 kept R1)
    send_pkt(8'h10, 4, EOP1, 0, 1'b0);
    send_pkt(8'h32, 2, EOP2, 2, 1'b0);
    // R4: local
    send_pkt(8'h40, 3, EOP1, LOC, 1'b0);
    drain("R3/R4/R11 drain");

    // R5: own address is a miss
    exp_irq++;
    send_pkt(8'h21, 2, EOP1, LOC, 1'b0);
    // R6: unknown address
    exp_irq++;
    send_pkt(8'h99, 1, EOP2, LOC, 1'b0);
    drain("R5/R6 drain");

    // R6: masked
    irq_mask = 1'b1;
    send_pkt(8'h77, 2, EOP1, LOC, 1'b0);
    drain("R6 masked");
    irq_mask = 1'b0;

    // R10: L0 and L2 both 0x10, node too -> link 0
    link_addr = {8'h10, 8'h21, 8'h10};
    node_addr = 8'h10;
    send_pkt(8'h10, 2, EOP1, 0, 1'b0);
    // R10: L0 moved, L2 still beats node
    link_addr = {8'h10, 8'h21, 8'h55};
    send_pkt(8'h10, 2, EOP2, 2, 1'b0);
    // R10: header matches own link and node -> local, no irq
    link_addr = {8'h32, 8'h10, 8'h55};
    send_pkt(8'h10, 1, EOP1, LOC, 1'b0);
    drain("R10 drain");
    link_addr = {8'h32, 8'h21, 8'h10};
    node_addr = 8'h40;

    // R8: random backpressure across packets
    stall_en = 1'b1;
    for (int p = 0; p < 12; p++) begin
      case (p % 4)
        0: send_pkt(8'h10, 5, EOP1, 0, 1'b0);
        1: send_pkt(8'h32, 6, EOP2, 2, 1'b0);
        2: send_pkt(8'h40, 4, EOP1, LOC, 1'b0);
        default: begin exp_irq++; send_pkt(8'hAB, 3, EOP2, LOC, 1'b0); end
      endcase
    end
    stall_en = 1'b0;
    drain("R8 stall drain");

    finish_up();
  end
endmodule